// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of a parameterised width and returns their full double-width signed product. It works serially, one recoding step per clock. Each step looks at the lowest multiplier bit and the bit shifted out before it. That pair decides whether the multiplicand is subtracted from the running partial product, added to it, or neither. The whole partial-product/multiplier chain then shifts right by one place, keeping the sign. Signed operands, including the most negative value, need no pre- or post-conversion.

A caller pulses `start` while the block is idle, with both operands on the inputs. `busy` rises on the next cycle and stays high for exactly `WIDTH` cycles. `done` then pulses for one cycle and the product is valid. The product holds until the next accepted start. A new start may be given in the same cycle that `done` is high.

Top module: `booth_mult`

## Requirements
- R1: While `rstN` is low, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen at a clock edge while `busy` is low is accepted and captures both operands, and `busy` is 1 in the next cycle.
- R3: After an accepted start, `busy` stays high for exactly `WIDTH` cycles. Then `done` is 1 for exactly one cycle with `busy` low. `busy` and `done` are never both high.
- R4: When `done` is high, `product` equals the signed product of `multiplicand` and `multiplier` as captured at the accepted start, as a `2*WIDTH`-bit two's-complement value. This holds for every operand pair, including the most negative value on either or both inputs.
- R5: A `start` that arrives while `busy` is high is ignored. Neither the operands offered with it nor the pulse itself change the running product or the timing of `busy` and `done`.
- R6: While `busy` is low and no start is accepted, `product` keeps its value.
- R7: A start accepted in the same cycle that `done` is high begins a new run with the R3 timing and the R4 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | High while recoding steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product; valid from `done` until the next accepted start |

## Verification
The assertions assume that the operands are only meaningful in the cycle in which `start` is accepted. They also assume that any `start` during a run is a stray request that the block must drop. So the checker captures the operands only on an accepted start and sets the run length from the first `busy` cycle. The stimulus keeps changing the operand inputs while the block is busy, holds `start` high across the first cycles of some runs, and issues most new requests in the `done` cycle. The accepted/ignored distinction is therefore exercised at its edges. Width 5 is covered over all operand pairs, and width 8 over its extreme values and random pairs.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } boothStrobe_t;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_t;

  // Pair (current low multiplier bit, previously shifted-out bit)
  function automatic boothOp_t recode(input logic qLow, input logic qPrev);
    case ({qLow, qPrev})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] operand,
  input  boothOp_t         op,
  output logic [WIDTH-1:0] result
);

  always_comb begin
    unique case (op)
      OP_ADD:  result = acc + operand;
      OP_SUB:  result = acc - operand;
      default: result = acc;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output boothStrobe_t strobe,
  output logic         busy,
  output logic         done
);

  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] stepCnt;
  logic          lastStep;

  assign lastStep = (stepCnt == CW'(WIDTH - 1));

  always_comb begin
    strobe.load = start && !busy;
    strobe.step = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
        if (lastStep) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/booth_dpath.sv
module booth_dpath
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  boothStrobe_t         strobe,
  input  logic [WIDTH-1:0]     mcandIn,
  input  logic [WIDTH-1:0]     mplrIn,
  output logic [2*WIDTH-1:0]   product
);

  // One guard bit on the accumulator keeps A - M exact for the most negative M
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    accA;
  logic [AW-1:0]    mcand;
  logic [AW-1:0]    nextA;
  logic [WIDTH-1:0] mplr;
  logic             qPrev;
  boothOp_t         op;

  assign op = recode(mplr[0], qPrev);

  booth_addsub #(.WIDTH(AW)) u_addsub (
    .acc     (accA),
    .operand (mcand),
    .op      (op),
    .result  (nextA)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accA  <= '0;
      mcand <= '0;
      mplr  <= '0;
      qPrev <= 1'b0;
    end else if (strobe.load) begin
      accA  <= '0;
      mcand <= {mcandIn[WIDTH-1], mcandIn};
      mplr  <= mplrIn;
      qPrev <= 1'b0;
    end else if (strobe.step) begin
      accA  <= {nextA[AW-1], nextA[AW-1:1]};
      mplr  <= {nextA[0], mplr[WIDTH-1:1]};
      qPrev <= mplr[0];
    end
  end

  assign product = {accA[WIDTH-1:0], mplr};

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  boothStrobe_t strobe;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  booth_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mcandIn (multiplicand),
    .mplrIn  (multiplier),
    .product (product)
  );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0]   capM;
  logic [WIDTH-1:0]   capQ;
  int unsigned        busyRun;
  logic [2*WIDTH-1:0] expProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capM    <= '0;
      capQ    <= '0;
      busyRun <= 0;
    end else if (start && !busy) begin
      capM    <= multiplicand;
      capQ    <= multiplier;
      busyRun <= 0;
    end else if (busy) begin
      busyRun <= busyRun + 1;
    end
  end

  assign expProd = $signed({{WIDTH{capM[WIDTH-1]}}, capM}) *
                   $signed({{WIDTH{capQ[WIDTH-1]}}, capQ});

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |-> (!busy && !done));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R3
  run_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == WIDTH));

  // R4
  product_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == expProd));

  // R5
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (busyRun + 1 < WIDTH)) |=> (busy && !done));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_booth_mult_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/test_booth_mult.sv
`timescale 1ns/1ps
module test_booth_mult;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        start8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy8, done8;
  logic [15:0] prod8;

  logic        start5 = 1'b0;
  logic [4:0]  a5 = '0, b5 = '0;
  logic        busy5, done5;
  logic [9:0]  prod5;

  int checks = 0;
  int fails  = 0;

  booth_mult #(.WIDTH(8)) i_booth_mult (
    .clk(clk), .rstN(rstN), .start(start8), .multiplicand(a8), .multiplier(b8),
    .busy(busy8), .done(done8), .product(prod8)
  );

  booth_mult #(.WIDTH(5)) i_booth_mult_w5 (
    .clk(clk), .rstN(rstN), .start(start5), .multiplicand(a5), .multiplier(b5),
    .busy(busy5), .done(done5), .product(prod5)
  );

  // Behavioural reference, one entry per instance (0: width 8, 1: width 5)
  bit     mBusy[2], mDone[2], mIgn[2], mB2b[2];
  int     mLeft[2];
  longint mProd[2], mPend[2];

  task automatic cmp(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mstep(input int k, input int w, input logic st,
                       input longint a, input longint b);
    bit wasDone;
    longint mask;
    mask = (longint'(1) << (2 * w)) - 1;
    if (!rstN) begin
      mBusy[k] = 0; mDone[k] = 0; mLeft[k] = 0; mProd[k] = 0;
      mIgn[k] = 0; mB2b[k] = 0;
      return;
    end
    wasDone  = mDone[k];
    mDone[k] = 0;
    if (mBusy[k]) begin
      if (st) mIgn[k] = 1;
      mLeft[k]--;
      if (mLeft[k] == 0) begin
        mBusy[k] = 0;
        mDone[k] = 1;
        mProd[k] = mPend[k];
      end
    end else if (st) begin
      mBusy[k] = 1;
      mLeft[k] = w;
      mPend[k] = (a * b) & mask;
      mIgn[k]  = 0;
      mB2b[k]  = wasDone;
    end
  endtask

  task automatic mcmp(input int k, input logic b, input logic d, input longint p);
    string tag;
    if (!rstN) begin
      cmp("R1", longint'(b), 0);
      cmp("R1", longint'(d), 0);
      cmp("R1", p, 0);
      return;
    end
    cmp("R2", longint'(b), longint'(mBusy[k]));
    cmp("R3", longint'(d), longint'(mDone[k]));
    if (!mBusy[k]) begin
      if (mDone[k]) tag = mIgn[k] ? "R5" : (mB2b[k] ? "R7" : "R4");
      else          tag = "R6";
      cmp(tag, p, mProd[k]);
    end
  endtask

  always @(posedge clk) begin
    mstep(0, 8, start8, longint'($signed(a8)), longint'($signed(b8)));
    mstep(1, 5, start5, longint'($signed(a5)), longint'($signed(b5)));
    #1;
    mcmp(0, busy8, done8, longint'(prod8));
    mcmp(1, busy5, done5, longint'(prod5));
  end

  // mode 0: back to back, 1: start held into the run with other operands, 2: idle gap first
  task automatic run8(input logic [7:0] a, input logic [7:0] b, input int mode);
    if (mode == 2) @(negedge clk);
    start8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk);
    if (mode == 1) begin
      for (int i = 0; i < 3; i++) begin
        a8 = ~a; b8 = b + 8'd3;
        @(negedge clk);
      end
    end
    start8 = 1'b0; a8 = b ^ 8'h5a; b8 = a;
    while (!done8) @(negedge clk);
  endtask

  task automatic run5(input logic [4:0] a, input logic [4:0] b, input int mode);
    if (mode == 2) @(negedge clk);
    start5 = 1'b1; a5 = a; b5 = b;
    @(negedge clk);
    if (mode == 1) begin
      for (int i = 0; i < 3; i++) begin
        a5 = ~a; b5 = b + 5'd3;
        @(negedge clk);
      end
    end
    start5 = 1'b0; a5 = b; b5 = ~a;
    while (!done5) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        // R4 extremes at width 8
        run8(8'h80, 8'h80, 0);
        run8(8'h80, 8'h7f, 0);
        run8(8'h7f, 8'h80, 2);
        run8(8'h7f, 8'h7f, 0);
        run8(8'hff, 8'hff, 1);
        run8(8'h00, 8'h80, 0);
        run8(8'h03, 8'h07, 2);
        for (int i = 0; i < 600; i++)
          run8(8'($urandom), 8'($urandom), i % 3);
        // exhaustive width 5
        for (int i = 0; i < 32; i++)
          for (int j = 0; j < 32; j++)
            run5(5'(i), 5'(j), (i + j) % 3);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule